// File: doc/BRIEF.md
# Eight-Operation Shared-Adder ALU

This block is a purely combinational arithmetic-logic unit for 8-bit operands. A 3-bit operation code picks one of eight results: a sum or a difference formed on one adder, a multiply or divide by eight formed as fixed shifts, bitwise NAND, bitwise XOR, bitwise complement of the first operand, and a mirror image of the first operand's bits. The result follows the inputs within the same evaluation. There is no clock, no reset and no stored state.

The operation code is read with its most significant bit first. Codes 000 and 001 use the adder. Codes 010 and 011 use the shifter. Codes 100 and 101 use both operands bitwise. Codes 110 and 111 transform the first operand alone. A carry output from the adder is provided for debug. It reads 0 whenever the adder result is not the one selected.

Top module: `opsel_alu`

## Requirements
- R1: With op_sel_i = 3'b000, res_o equals (opa_i − opb_i) modulo 256.
- R2: With op_sel_i = 3'b001, res_o equals (opa_i + opb_i) modulo 256.
- R3: With op_sel_i = 3'b010, res_o equals opa_i shifted left by three places, with zeros filled in from the right and the upper bits discarded, that is (opa_i × 8) modulo 256.
- R4: With op_sel_i = 3'b011, res_o equals opa_i shifted right by three places with zero fill, that is opa_i / 8 with the fraction discarded.
- R5: With op_sel_i = 3'b100, res_o equals the bitwise NAND of opa_i and opb_i.
- R6: With op_sel_i = 3'b101, res_o equals the bitwise XOR of opa_i and opb_i.
- R7: With op_sel_i = 3'b110, res_o bit i equals opa_i bit 7−i for every i from 0 to 7.
- R8: With op_sel_i = 3'b111, res_o equals the bitwise complement of opa_i.
- R9: carry_o is bit 8 of opa_i + opb_i under code 001. It is 1 exactly when opa_i ≥ opb_i (no borrow) under code 000. It is 0 under every other code.
- R10: Under codes 010, 011, 110 and 111, opb_i has no effect on res_o or carry_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | 8 | First operand |
| opb_i | input | 8 | Second operand |
| op_sel_i | input | 3 | Operation code, most significant bit first |
| res_o | output | 8 | Selected result |
| carry_o | output | 1 | Adder carry out (debug), 0 for non-adder codes |

## Verification
The block holds no state, so an internal fault shows up at once. A wrong bit in the adder's inverted operand, its carry-in, a shift amount, a mirror wire or a select arm appears on res_o or carry_o in the same evaluation as the input that reaches it. The sweep applies every operand pair under every code. Any miswired bit or misrouted case arm therefore appears on at least one vector, with no latency to wait for. Separate probes hold opa_i fixed and change opb_i for the single-operand codes. This catches any leak of the second operand into those results.

// File: rtl/opsel_alu_pkg.sv
package opsel_alu_pkg;

    // Operation codes: most significant bit first, decoded by the top mux.
    typedef enum logic [2:0] {
        OP_DIFF   = 3'b000,
        OP_SUM    = 3'b001,
        OP_MUL8   = 3'b010,
        OP_DIV8   = 3'b011,
        OP_NAND   = 3'b100,
        OP_XOR    = 3'b101,
        OP_MIRROR = 3'b110,
        OP_INVERT = 3'b111
    } alu_op_e;

    localparam int unsigned OP_BITS = 3;

endpackage

// File: rtl/opsel_alu_addsub.sv
module opsel_alu_addsub #(
    parameter int unsigned WIDTH = 8
) (
    input  logic [WIDTH-1:0] lhs_i,
    input  logic [WIDTH-1:0] rhs_i,
    input  logic             minus_i,
    output logic [WIDTH-1:0] total_o,
    output logic             cout_o
);

    localparam int unsigned EXT = WIDTH + 1;

    logic [WIDTH-1:0] rhs_eff;
    logic [EXT-1:0]   wide_sum;

    // Subtraction: invert the second operand and inject a carry of one.
    assign rhs_eff  = rhs_i ^ {WIDTH{minus_i}};
    assign wide_sum = EXT'(lhs_i) + EXT'(rhs_eff) + EXT'(minus_i);
    assign total_o  = wide_sum[WIDTH-1:0];
    assign cout_o   = wide_sum[WIDTH];

endmodule

// File: rtl/opsel_alu_bitwise.sv
module opsel_alu_bitwise #(
    parameter int unsigned WIDTH = 8
) (
    input  logic [WIDTH-1:0] lhs_i,
    input  logic [WIDTH-1:0] rhs_i,
    output logic [WIDTH-1:0] nand_o,
    output logic [WIDTH-1:0] xor_o,
    output logic [WIDTH-1:0] inv_o
);

    assign nand_o = ~(lhs_i & rhs_i);
    assign xor_o  = lhs_i ^ rhs_i;
    assign inv_o  = ~lhs_i;

endmodule

// File: rtl/opsel_alu_reshape.sv
module opsel_alu_reshape #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned SHAMT = 3
) (
    input  logic [WIDTH-1:0] src_i,
    output logic [WIDTH-1:0] up_o,
    output logic [WIDTH-1:0] down_o,
    output logic [WIDTH-1:0] mirror_o
);

    localparam int unsigned KEEP = WIDTH - SHAMT;

    // Fixed logical shifts with zero fill.
    assign up_o   = {src_i[KEEP-1:0], {SHAMT{1'b0}}};
    assign down_o = {{SHAMT{1'b0}}, src_i[WIDTH-1:SHAMT]};

    // Mirror: output bit k takes input bit WIDTH-1-k.
    for (genvar k = 0; k < WIDTH; k++) begin : g_mirror
        assign mirror_o[k] = src_i[WIDTH-1-k];
    end

endmodule

// File: rtl/opsel_alu.sv
module opsel_alu
    import opsel_alu_pkg::*;
#(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned SHAMT = 3
) (
    input  logic [WIDTH-1:0]   opa_i,
    input  logic [WIDTH-1:0]   opb_i,
    input  logic [OP_BITS-1:0] op_sel_i,
    output logic [WIDTH-1:0]   res_o,
    output logic               carry_o
);

    alu_op_e          op;
    logic [WIDTH-1:0] arith_res;
    logic             arith_cout;
    logic [WIDTH-1:0] nand_res;
    logic [WIDTH-1:0] xor_res;
    logic [WIDTH-1:0] inv_res;
    logic [WIDTH-1:0] up_res;
    logic [WIDTH-1:0] down_res;
    logic [WIDTH-1:0] mirror_res;

    assign op = alu_op_e'(op_sel_i);

    opsel_alu_addsub #(.WIDTH(WIDTH)) u_addsub (
        .lhs_i   (opa_i),
        .rhs_i   (opb_i),
        .minus_i (op == OP_DIFF),
        .total_o (arith_res),
        .cout_o  (arith_cout)
    );

    opsel_alu_bitwise #(.WIDTH(WIDTH)) u_bitwise (
        .lhs_i  (opa_i),
        .rhs_i  (opb_i),
        .nand_o (nand_res),
        .xor_o  (xor_res),
        .inv_o  (inv_res)
    );

    opsel_alu_reshape #(.WIDTH(WIDTH), .SHAMT(SHAMT)) u_reshape (
        .src_i    (opa_i),
        .up_o     (up_res),
        .down_o   (down_res),
        .mirror_o (mirror_res)
    );

    always_comb begin
        res_o   = '0;
        carry_o = 1'b0;
        unique case (op)
            OP_DIFF, OP_SUM: begin
                res_o   = arith_res;
                carry_o = arith_cout;
            end
            OP_MUL8:   res_o = up_res;
            OP_DIV8:   res_o = down_res;
            OP_NAND:   res_o = nand_res;
            OP_XOR:    res_o = xor_res;
            OP_MIRROR: res_o = mirror_res;
            OP_INVERT: res_o = inv_res;
            default:   res_o = '0;
        endcase
    end

endmodule

// File: rtl/opsel_alu_chk.sv
module opsel_alu_chk #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned SHAMT = 3
) (
    input logic [WIDTH-1:0] opa_i,
    input logic [WIDTH-1:0] opb_i,
    input logic [2:0]       op_sel_i,
    input logic [WIDTH-1:0] res_o,
    input logic             carry_o
);

    localparam int unsigned EXT = WIDTH + 1;

    logic [EXT-1:0] ref_sum;
    logic [WIDTH-1:0] ref_rev;

    always_comb begin
        ref_sum = EXT'(opa_i) + EXT'(opb_i);
        for (int i = 0; i < WIDTH; i++) begin
            ref_rev[i] = opa_i[WIDTH-1-i];
        end
    end

    always_comb begin
        if (op_sel_i == 3'b000) begin
            assert_diff_R1: assert (res_o == WIDTH'(opa_i - opb_i))
                else $error("R1 difference mismatch");
        end
        if (op_sel_i == 3'b001) begin
            assert_sum_R2: assert (res_o == ref_sum[WIDTH-1:0])
                else $error("R2 sum mismatch");
        end
        if (op_sel_i == 3'b010) begin
            assert_mul8_R3: assert (res_o == WIDTH'(opa_i * (2 ** SHAMT)))
                else $error("R3 multiply-by-eight mismatch");
        end
        if (op_sel_i == 3'b011) begin
            assert_div8_R4: assert (res_o == WIDTH'(opa_i / (2 ** SHAMT)))
                else $error("R4 divide-by-eight mismatch");
        end
        if (op_sel_i == 3'b100) begin
            assert_nand_R5: assert ((res_o & opa_i & opb_i) == '0 && (res_o | (opa_i & opb_i)) == '1)
                else $error("R5 nand mismatch");
        end
        if (op_sel_i == 3'b101) begin
            assert_xor_R6: assert ((res_o ^ opb_i) == opa_i)
                else $error("R6 xor mismatch");
        end
        if (op_sel_i == 3'b110) begin
            assert_mirror_R7: assert (res_o == ref_rev)
                else $error("R7 mirror mismatch");
        end
        if (op_sel_i == 3'b111) begin
            assert_invert_R8: assert ((res_o + opa_i) == '1)
                else $error("R8 complement mismatch");
        end
        if (op_sel_i == 3'b001) begin
            assert_sum_carry_R9: assert (carry_o == ref_sum[WIDTH])
                else $error("R9 sum carry mismatch");
        end
        if (op_sel_i == 3'b000) begin
            assert_diff_carry_R9: assert (carry_o == (opa_i >= opb_i))
                else $error("R9 difference carry mismatch");
        end
        if (op_sel_i[2:1] != 2'b00) begin
            assert_no_carry_R9: assert (carry_o == 1'b0)
                else $error("R9 carry set outside adder codes");
        end
    end

endmodule

bind opsel_alu opsel_alu_chk #(.WIDTH(WIDTH), .SHAMT(SHAMT)) u_opsel_alu_chk (
    .opa_i    (opa_i),
    .opb_i    (opb_i),
    .op_sel_i (op_sel_i),
    .res_o    (res_o),
    .carry_o  (carry_o)
);

// File: tb/opsel_alu_bench.sv
`timescale 1ns/1ps
module opsel_alu_bench;

    logic       clk = 1'b0;
    logic [7:0] opa;
    logic [7:0] opb;
    logic [2:0] op_sel;
    logic [7:0] res;
    logic       carry;

    int tests_run = 0;
    int tests_failed = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    opsel_alu u_opsel_alu (
        .opa_i    (opa),
        .opb_i    (opb),
        .op_sel_i (op_sel),
        .res_o    (res),
        .carry_o  (carry)
    );

    function automatic string tag_of(input int code);
        case (code)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            3: return "R4";
            4: return "R5";
            5: return "R6";
            6: return "R7";
            default: return "R8";
        endcase
    endfunction

    function automatic int exp_res(input int code, input int a, input int b);
        int r;
        r = 0;
        case (code)
            0: r = (a - b + 256) % 256;
            1: r = (a + b) % 256;
            2: r = (a * 8) % 256;
            3: r = a / 8;
            4: r = 255 - (a & b);
            5: r = (a | b) - (a & b);
            6: for (int i = 0; i < 8; i++) if (((a >> i) & 1) != 0) r = r + (1 << (7 - i));
            default: r = 255 - a;
        endcase
        return r;
    endfunction

    function automatic int exp_carry(input int code, input int a, input int b);
        if (code == 0) return (a >= b) ? 1 : 0;
        if (code == 1) return (a + b > 255) ? 1 : 0;
        return 0;
    endfunction

    task automatic check(input string tag, input int act, input int exp, input string what);
        tests_run++;
        if (act != exp) begin
            tests_failed++;
            $display("FAIL %s %s: actual %0d expected %0d (op %0d a %0d b %0d)",
                     tag, what, act, exp, op_sel, opa, opb);
        end
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (!done && cycles > 190000) begin
            done = 1'b1;
            tests_run++;
            tests_failed++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
            $finish;
        end
    end

    initial begin
        int base;
        opa = 8'd0; opb = 8'd0; op_sel = 3'd0;
        #1.2;

        // Exhaustive sweep: every code, every operand pair (R1..R9).
        for (int code = 0; code < 8; code++) begin
            for (int a = 0; a < 256; a++) begin
                for (int b = 0; b < 256; b++) begin
                    op_sel = code[2:0]; opa = a[7:0]; opb = b[7:0];
                    #1;
                    check(tag_of(code), int'(res), exp_res(code, a, b), "result");
                    check("R9", int'(carry), exp_carry(code, a, b), "carry");
                end
            end
        end

        // R10: second operand must not reach single-operand results.
        for (int code = 2; code < 8; code++) begin
            if (code == 4 || code == 5) continue;
            for (int a = 0; a < 256; a += 17) begin
                op_sel = code[2:0]; opa = a[7:0]; opb = 8'h00;
                #1;
                base = int'({carry, res});
                for (int b = 1; b < 256; b += 37) begin
                    opb = b[7:0];
                    #1;
                    check("R10", int'({carry, res}), base, "operand-B leak");
                end
            end
        end

        // Corner spot checks named by requirement.
        op_sel = 3'b000; opa = 8'h00; opb = 8'h01; #1;
        check("R1", int'(res), 255, "0-1 wrap");
        check("R9", int'(carry), 0, "borrow");
        op_sel = 3'b001; opa = 8'hFF; opb = 8'h01; #1;
        check("R2", int'(res), 0, "FF+1 wrap");
        check("R9", int'(carry), 1, "carry out");
        op_sel = 3'b110; opa = 8'h01; #1;
        check("R7", int'(res), 128, "mirror lsb");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

endmodule